// File: doc/BRIEF.md
# Banked GPIO Data and Direction Register File

This block holds the data-path registers for a group of general-purpose pins. The pins are split into register sets of one bus word each. Every set has five registers. The direction register marks each pin as an input (bit 1) or an output whose pad driver is enabled (bit 0). The output latch sets the level driven on each pad. It can be changed atomically through a write-one-to-set word or a write-one-to-clear word. It can also be loaded directly through the output-data word, which lets software restore a saved state in one write. The input-data word returns the pad levels after a multi-stage synchroniser.

The register sets share one byte-addressed, word-wide register port with a single-cycle write and a combinational read. Set `s` starts at `BASE_OFFSET + s*SET_STRIDE`. Inside a set, the words follow a fixed order in 4-byte steps: direction (+0x0), output data (+0x4), set data (+0x8), clear data (+0xC), input data (+0x10). The remaining words of each stride are kept for interrupt-edge control, which lives elsewhere. In this block those words read as zero and ignore writes. The pad outputs and pad enables come straight from the stored state.

Top module: `gpio_banked_regs`

## Requirements
- R1: While reset is held and right after it, every direction bit is 1 and every output latch bit is 0. As a result, pad_oe and pad_out are all zeros and each direction word reads 0xFFFFFFFF.
- R2: pad_oe of a pin is the inverse of its direction bit. A 0 written to the direction word (+0x0) enables that pad driver from the clock edge that takes the write.
- R3: A write to the set-data word (+0x8) sets every latch bit whose written bit is 1 and leaves all other latch bits unchanged.
- R4: A write to the clear-data word (+0xC) clears every latch bit whose written bit is 1 and leaves all other latch bits unchanged.
- R5: A write to the output-data word (+0x4) loads the whole latch with the written value.
- R6: Reads return the stored state. The direction word gives the direction bits. The output-data, set-data and clear-data words all give the current latch value.
- R7: The input-data word (+0x10) returns the pad level after two clock edges. A change on the pad read after one edge still returns the old level. This holds whether the pin is an input or an output.
- R8: Set s occupies the byte addresses BASE_OFFSET + s*SET_STRIDE onwards (0x10, 0x38, 0x60 with the defaults). A write to one set changes no pin of any other set.
- R9: The following accesses leave all pads and registers unchanged, and reads of them return 0: writes to the input-data word, to the interrupt-edge words (+0x14 to +0x24), to misaligned addresses, or to addresses outside every set. Cycles with no write also change nothing.
- R10: pad_out always shows the latch, including pins configured as inputs, so an output keeps its preset level at the moment it is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register and synchroniser clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | PINS | Write data |
| bus_rdata | output | PINS | Read data, combinational, 0 when no read is selected |
| pad_in | input | NUM_SETS*PINS | Asynchronous pad levels |
| pad_out | output | NUM_SETS*PINS | Output latch, one bit per pin |
| pad_oe | output | NUM_SETS*PINS | Pad driver enable, one bit per pin |

## Verification
A wrong direction bit or latch bit shows at pad_oe or pad_out on the cycle after the write that caused it. It also shows on any later read of the direction, output-data, set-data or clear-data words, so a corruption cannot hide between accesses. A fault in the address decode shows as a change to a neighbouring set's pads in that same cycle, which is why every write is followed by a check of all sets. A synchroniser with the wrong depth only shows in the cycle-exact timing of the input-data read: one edge too few or too many, counted from the pad change.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
   // word positions inside one register set; the order is part of the address map
   localparam int unsigned WORD_BYTES = 4;
   localparam int unsigned W_DIR = 0;
   localparam int unsigned W_OUT = 1;
   localparam int unsigned W_SET = 2;
   localparam int unsigned W_CLR = 3;
   localparam int unsigned W_IN  = 4;
   localparam int unsigned DATA_WORDS = 5;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int unsigned WIDTH  = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] stg [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) stg[0] <= '0;
            else        stg[0] <= d;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) stg[i] <= '0;
            else        stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec #(
   parameter int unsigned NUM_SETS    = 3,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned BASE_OFFSET = 16,
   parameter int unsigned SET_STRIDE  = 40,
   parameter int unsigned WORD_W      = 4
) (
   input  logic [ADDR_W-1:0]   addr,
   output logic [NUM_SETS-1:0] set_hit,
   output logic [WORD_W-1:0]   word
);
   localparam int unsigned XW = ADDR_W + 1;

   logic [XW-1:0] addr_x;
   assign addr_x = {1'b0, addr};

   for (genvar s = 0; s < NUM_SETS; s++) begin : g_win
      localparam logic [XW-1:0] LO = XW'(BASE_OFFSET + s*SET_STRIDE);
      localparam logic [XW-1:0] HI = XW'(BASE_OFFSET + (s+1)*SET_STRIDE);
      assign set_hit[s] = (addr_x >= LO) && (addr_x < HI) && (addr[1:0] == 2'b00);
   end

   always_comb begin
      word = '0;
      for (int s = 0; s < NUM_SETS; s++) begin
         logic [XW-1:0] rel;
         rel = addr_x - XW'(BASE_OFFSET + s*SET_STRIDE);
         if (set_hit[s]) word = WORD_W'(rel >> 2);
      end
   end
endmodule

// File: rtl/gpio_reg_set.sv
module gpio_reg_set
   import gpio_bank_pkg::*;
#(
   parameter int unsigned PINS        = 32,
   parameter int unsigned WORD_W      = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] word,
   input  logic [PINS-1:0]   wdata,
   input  logic [PINS-1:0]   pad_in,
   output logic [PINS-1:0]   rdata,
   output logic [PINS-1:0]   pad_out,
   output logic [PINS-1:0]   pad_oe
);
   logic [PINS-1:0] dir_q, lat_q, lat_d, in_sync;
   logic [PINS-1:0] set_mask, clr_mask;
   logic            wr_dir, wr_out;

   assign wr_dir   = wr_en && (word == WORD_W'(W_DIR));
   assign wr_out   = wr_en && (word == WORD_W'(W_OUT));
   assign set_mask = (wr_en && (word == WORD_W'(W_SET))) ? wdata : '0;
   assign clr_mask = (wr_en && (word == WORD_W'(W_CLR))) ? wdata : '0;

   // clear wins over set on a shared bit
   always_comb begin
      if (wr_out) lat_d = wdata;
      else        lat_d = (lat_q | set_mask) & ~clr_mask;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q <= '1;
         lat_q <= '0;
      end else begin
         if (wr_dir) dir_q <= wdata;
         lat_q <= lat_d;
      end
   end

   gpio_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_in),
      .q     (in_sync)
   );

   always_comb begin
      unique case (word)
         WORD_W'(W_DIR): rdata = dir_q;
         WORD_W'(W_OUT),
         WORD_W'(W_SET),
         WORD_W'(W_CLR): rdata = lat_q;
         WORD_W'(W_IN):  rdata = in_sync;
         default:        rdata = '0;
      endcase
   end

   assign pad_out = lat_q;
   assign pad_oe  = ~dir_q;
endmodule

// File: rtl/gpio_banked_regs.sv
module gpio_banked_regs
   import gpio_bank_pkg::*;
#(
   parameter int unsigned NUM_SETS    = 3,
   parameter int unsigned PINS        = 32,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned BASE_OFFSET = 16,
   parameter int unsigned SET_STRIDE  = 40,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     bus_sel,
   input  logic                     bus_we,
   input  logic [ADDR_W-1:0]        bus_addr,
   input  logic [PINS-1:0]          bus_wdata,
   output logic [PINS-1:0]          bus_rdata,
   input  logic [NUM_SETS*PINS-1:0] pad_in,
   output logic [NUM_SETS*PINS-1:0] pad_out,
   output logic [NUM_SETS*PINS-1:0] pad_oe
);
   localparam int unsigned STRIDE_WORDS = SET_STRIDE / WORD_BYTES;
   localparam int unsigned WORD_W       = $clog2(STRIDE_WORDS);
   localparam int unsigned MAP_END      = BASE_OFFSET + NUM_SETS*SET_STRIDE;

   if (NUM_SETS < 1) begin : g_bad_sets
      $error("NUM_SETS must be at least 1");
   end
   if (PINS < 1 || PINS > 32) begin : g_bad_pins
      $error("PINS must be 1..32");
   end
   if (SET_STRIDE % WORD_BYTES != 0 || STRIDE_WORDS < DATA_WORDS) begin : g_bad_stride
      $error("SET_STRIDE must be word aligned and hold the data words");
   end
   if (BASE_OFFSET % WORD_BYTES != 0) begin : g_bad_base
      $error("BASE_OFFSET must be word aligned");
   end
   if (MAP_END > (1 << ADDR_W)) begin : g_bad_map
      $error("register sets do not fit in ADDR_W");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [NUM_SETS-1:0] set_hit;
   logic [WORD_W-1:0]   word;
   logic [PINS-1:0]     rd_w [NUM_SETS];

   gpio_addr_dec #(
      .NUM_SETS    (NUM_SETS),
      .ADDR_W      (ADDR_W),
      .BASE_OFFSET (BASE_OFFSET),
      .SET_STRIDE  (SET_STRIDE),
      .WORD_W      (WORD_W)
   ) u_dec (
      .addr    (bus_addr),
      .set_hit (set_hit),
      .word    (word)
   );

   for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
      gpio_reg_set #(
         .PINS        (PINS),
         .WORD_W      (WORD_W),
         .SYNC_STAGES (SYNC_STAGES)
      ) u_set (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (bus_sel && bus_we && set_hit[s]),
         .word    (word),
         .wdata   (bus_wdata),
         .pad_in  (pad_in[s*PINS +: PINS]),
         .rdata   (rd_w[s]),
         .pad_out (pad_out[s*PINS +: PINS]),
         .pad_oe  (pad_oe[s*PINS +: PINS])
      );
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_sel && !bus_we)
         for (int s = 0; s < NUM_SETS; s++)
            if (set_hit[s]) bus_rdata = bus_rdata | rd_w[s];
   end
endmodule

// File: rtl/gpio_banked_regs_chk.sv
module gpio_banked_regs_chk #(
   parameter int unsigned NUM_SETS    = 3,
   parameter int unsigned PINS        = 32,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned BASE_OFFSET = 16,
   parameter int unsigned SET_STRIDE  = 40,
   parameter int unsigned SYNC_STAGES = 2
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     bus_sel,
   input logic                     bus_we,
   input logic [ADDR_W-1:0]        bus_addr,
   input logic [PINS-1:0]          bus_wdata,
   input logic [PINS-1:0]          bus_rdata,
   input logic [NUM_SETS*PINS-1:0] pad_in,
   input logic [NUM_SETS*PINS-1:0] pad_out,
   input logic [NUM_SETS*PINS-1:0] pad_oe
);
   logic rst_seen_q;
   always_ff @(posedge clk) rst_seen_q <= !rst_n;

   always @(posedge clk)
      if (!rst_n && rst_seen_q)
         p_reset_state_r1: assert (pad_out == '0 && pad_oe == '0);

   p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_sel && bus_we) |=> ($stable(pad_out) && $stable(pad_oe)));

   for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
      localparam logic [ADDR_W-1:0] A_DIR = ADDR_W'(BASE_OFFSET + s*SET_STRIDE);
      localparam logic [ADDR_W-1:0] A_OUT = ADDR_W'(BASE_OFFSET + s*SET_STRIDE + 4);
      localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(BASE_OFFSET + s*SET_STRIDE + 8);
      localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(BASE_OFFSET + s*SET_STRIDE + 12);
      localparam logic [ADDR_W-1:0] A_IN  = ADDR_W'(BASE_OFFSET + s*SET_STRIDE + 16);

      p_dir_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_sel && bus_we && bus_addr == A_DIR)
         |=> (pad_oe[s*PINS +: PINS] == ~$past(bus_wdata)));

      p_set_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_sel && bus_we && bus_addr == A_SET)
         |=> (pad_out[s*PINS +: PINS] == ($past(pad_out[s*PINS +: PINS]) | $past(bus_wdata))));

      p_clr_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_sel && bus_we && bus_addr == A_CLR)
         |=> (pad_out[s*PINS +: PINS] == ($past(pad_out[s*PINS +: PINS]) & ~$past(bus_wdata))));

      p_load_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_sel && bus_we && bus_addr == A_OUT)
         |=> (pad_out[s*PINS +: PINS] == $past(bus_wdata)));

      p_input_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_sel && bus_we && bus_addr == A_IN)
         |=> ($stable(pad_out) && $stable(pad_oe)));
   end
endmodule

bind gpio_banked_regs gpio_banked_regs_chk #(
   .NUM_SETS    (NUM_SETS),
   .PINS        (PINS),
   .ADDR_W      (ADDR_W),
   .BASE_OFFSET (BASE_OFFSET),
   .SET_STRIDE  (SET_STRIDE),
   .SYNC_STAGES (SYNC_STAGES)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_sel   (bus_sel),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .pad_in    (pad_in),
   .pad_out   (pad_out),
   .pad_oe    (pad_oe)
);

// File: tb/gpio_banked_regs_tb.sv
module gpio_banked_regs_tb;
   localparam int NS = 3;
   localparam int P  = 32;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            bus_sel = 1'b0, bus_we = 1'b0;
   logic [7:0]      bus_addr = '0;
   logic [P-1:0]    bus_wdata = '0;
   logic [P-1:0]    bus_rdata;
   logic [NS*P-1:0] pad_in = '0;
   logic [NS*P-1:0] pad_out, pad_oe;

   int checks = 0, failures = 0;
   logic [P-1:0] m_dir [NS];
   logic [P-1:0] m_lat [NS];

   always #5 clk = ~clk;

   gpio_banked_regs u_dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
   );

   function automatic logic [7:0] ra(int s, int w);
      return 8'(16 + s*40 + w*4);
   endfunction

   task automatic chk(string req, logic [P-1:0] act, logic [P-1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(logic [7:0] a, logic [P-1:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0;
   endtask

   task automatic rd(logic [7:0] a, output logic [P-1:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      bus_sel = 1'b0;
   endtask

   // every set's pads against the model
   task automatic chk_pads(string req);
      for (int s = 0; s < NS; s++) begin
         chk(req, pad_out[s*P +: P], m_lat[s]);
         chk(req, pad_oe[s*P +: P], ~m_dir[s]);
      end
   endtask

   task automatic t_reset;
      logic [P-1:0] v;
      chk_pads("R1");
      for (int s = 0; s < NS; s++) begin
         rd(ra(s, 0), v);
         chk("R1", v, '1);
      end
   endtask

   task automatic t_direction;
      logic [P-1:0] v;
      wr(ra(1, 0), 32'h0000_FFFF);
      m_dir[1] = 32'h0000_FFFF;
      chk_pads("R2");
      rd(ra(1, 0), v);
      chk("R6", v, 32'h0000_FFFF);
   endtask

   task automatic t_set;
      logic [P-1:0] v;
      wr(ra(0, 1), 32'h0F0F_0000); m_lat[0] = 32'h0F0F_0000;
      wr(ra(0, 2), 32'h0000_00FF); m_lat[0] = 32'h0F0F_00FF;
      chk_pads("R3");
      rd(ra(0, 2), v); chk("R6", v, m_lat[0]);
      rd(ra(0, 3), v); chk("R6", v, m_lat[0]);
      rd(ra(0, 1), v); chk("R6", v, m_lat[0]);
   endtask

   task automatic t_clear;
      wr(ra(0, 3), 32'h0F00_0001); m_lat[0] = 32'h000F_00FE;
      chk_pads("R4");
   endtask

   task automatic t_load;
      wr(ra(2, 1), 32'hA5A5_5A5A); m_lat[2] = 32'hA5A5_5A5A;
      chk_pads("R5");
      // set 2 is still all inputs, yet its latch is visible on pad_out
      chk("R10", pad_oe[2*P +: P], '0);
      chk("R10", pad_out[2*P +: P], 32'hA5A5_5A5A);
   endtask

   task automatic t_isolation;
      wr(ra(1, 2), '1); m_lat[1] = '1;
      chk_pads("R8");
      wr(ra(1, 3), 32'hFFFF_0000); m_lat[1] = 32'h0000_FFFF;
      chk_pads("R8");
   endtask

   task automatic t_ignored;
      logic [P-1:0] v;
      wr(ra(0, 4), '1);
      wr(ra(1, 5), '1);
      wr(ra(2, 9), '1);
      wr(8'h11, '1);
      wr(8'h0C, '1);
      wr(8'(16 + NS*40), '1);
      chk_pads("R9");
      rd(ra(1, 5), v); chk("R9", v, '0);
      rd(8'h15, v); chk("R9", v, '0);
      rd(8'(16 + NS*40), v); chk("R9", v, '0);
      for (int s = 0; s < NS; s++) begin
         rd(ra(s, 0), v); chk("R9", v, m_dir[s]);
         rd(ra(s, 1), v); chk("R9", v, m_lat[s]);
      end
   endtask

   task automatic t_sync;
      wr(ra(0, 0), '0); m_dir[0] = '0;
      chk_pads("R7");
      @(negedge clk);
      pad_in[0 +: P] = 32'h1234_5678;
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b0; bus_addr = ra(0, 4);
      #1 chk("R7", bus_rdata, 32'h0);
      @(negedge clk);
      #1 chk("R7", bus_rdata, 32'h1234_5678);
      bus_addr = ra(1, 4);
      #1 chk("R7", bus_rdata, 32'h0);
      bus_sel = 1'b0;
   endtask

   initial begin
      for (int s = 0; s < NS; s++) begin
         m_dir[s] = '1;
         m_lat[s] = '0;
      end
      repeat (3) @(negedge clk);
      t_reset();
      @(negedge clk) rst_n = 1'b1;
      t_reset();
      t_direction();
      t_set();
      t_clear();
      t_load();
      t_isolation();
      t_ignored();
      t_sync();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule